// File: doc/BRIEF.md
# Dual-Modulus Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. An external dual-modulus prescaler divides the oscillator by 32 or 33 and hands one strobe per prescaler cycle to the block. The block counts those strobes, steers the prescaler modulus, and emits one divided pulse every N oscillator cycles. N is a 15-bit ratio, so the loop runs the oscillator at N times the comparison frequency. For example, a 31.25 kHz comparison rate and a 101 MHz oscillator give N = 3232.

The ratio is split into a swallow count A = N[4:0] and a main count M = N[14:5]. In each output period the prescaler runs at 33 for the first A strobes and at 32 for the remaining M - A strobes. The period is therefore 33A + 32(M - A) = 32M + A = N oscillator cycles. Ratios below 1024 are raised to 1024. At that floor M is at least 32, so M always exceeds the largest A (31).

A new ratio written by the control side is held and reaches the counters only at the terminal count. Periods are therefore never shortened or stretched mid-way. For measurement, a test select routes the divided pulse onto a monitor pin that otherwise carries a static port level.

The counter sequencer has two states:
- **SWALLOW**: the prescaler is at /33, and both the swallow count and the main count decrement on every strobe. On the strobe where the swallow count is 1, it moves to MAIN (transition "swallow done").
- **MAIN**: the prescaler is at /32, and only the main count decrements. On the strobe where the main count is 1, the terminal count occurs: the counters reload, and the divided pulse follows. The next state is SWALLOW if the new A is nonzero (transition "reload to swallow"). Otherwise the state stays MAIN (transition "reload to main").

After reset the state is whichever of the two the reset ratio selects.

Top module: `swallow_fb_div`

## Requirements
- R1: After reset, div_pulse is 0 and the active ratio is RESET_RATIO (default 1024, which has A = 0), so mod_hi is 0.
- R2: With a prescaler that divides by 33 while mod_hi = 1 and by 32 while mod_hi = 0, consecutive div_pulse assertions are exactly N clock cycles apart.
- R3: Within one output period there are exactly M = N[14:5] prescaler strobes. Exactly A = N[4:0] of them occur while mod_hi = 1, and these come first. This includes the corner cases A = 0 and A = 31.
- R4: mod_hi changes value only in the cycle right after a cycle in which pre_tick was 1.
- R5: div_pulse is high for exactly one cycle, in the cycle after the strobe that reaches the terminal count. It is never high on two consecutive cycles.
- R6: A ratio written with ratio_wr in the middle of a period does not alter that period. The new ratio governs the period that follows. A write in the same cycle as the terminal strobe takes effect immediately.
- R7: A written ratio below 1024 is replaced by 1024.
- R8: mon_out equals div_pulse while test_sel = 1 and equals port_lvl while test_sel = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one cycle per oscillator cycle seen by the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_tick | input | 1 | One-cycle strobe at the end of each prescaler cycle |
| ratio_in | input | 15 | New division ratio N |
| ratio_wr | input | 1 | Write strobe for ratio_in |
| test_sel | input | 1 | 1 routes div_pulse to mon_out |
| port_lvl | input | 1 | Static level for mon_out in normal mode |
| mod_hi | output | 1 | Prescaler modulus: 1 = /33, 0 = /32 |
| div_pulse | output | 1 | One-cycle divided output pulse |
| mon_out | output | 1 | Monitor pin: divided pulse or port level |

## Verification
A swallow count that is off by one shifts the period by one cycle. A main count that is off by one shifts it by 32 cycles. Either error is visible at the first interval between div_pulse assertions after the faulty reload, one output period after the fault. A wrong SWALLOW/MAIN sequence shows as the wrong number of strobes seen with mod_hi high, or as mod_hi changing without a preceding strobe, on the cycle where it happens. A ratio applied at the wrong moment shows as an interval that is neither the old nor the new N in the period that straddles the write.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

    // Sequencer states of the swallow counter
    typedef enum logic [0:0] {
        ST_SWALLOW = 1'b0,   // prescaler at high modulus
        ST_MAIN    = 1'b1    // prescaler at low modulus
    } swd_state_e;

endpackage

// File: rtl/swd_ratio_reg.sv
module swd_ratio_reg #(
    parameter int NW          = 15,
    parameter int MIN_RATIO   = 1024,
    parameter int RESET_RATIO = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] ratio_in,
    input  logic          ratio_wr,
    output logic [NW-1:0] ratio_eff
);
    localparam logic [NW-1:0] FLOOR = NW'(MIN_RATIO);
    localparam logic [NW-1:0] RST_V = NW'(RESET_RATIO);

    logic [NW-1:0] held_q;
    logic [NW-1:0] clamped;

    // R7: raise small ratios to the floor
    always_comb begin
        clamped = (ratio_in < FLOOR) ? FLOOR : ratio_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= RST_V;
        end else if (ratio_wr) begin
            held_q <= clamped;
        end
    end

    // A write in the terminal cycle is seen by the reload at once (R6)
    always_comb begin
        ratio_eff = ratio_wr ? clamped : held_q;
    end
endmodule

// File: rtl/swd_count_fsm.sv
module swd_count_fsm
    import swallow_div_pkg::*;
#(
    parameter int NW          = 15,
    parameter int PW          = 5,
    parameter int RESET_RATIO = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [NW-1:0] load_ratio,
    output logic          mod_hi,
    output logic          term_pulse
);
    localparam int MW = NW - PW;
    localparam logic [NW-1:0] RST_V   = NW'(RESET_RATIO);
    localparam logic [MW-1:0] RST_M   = RST_V[NW-1:PW];
    localparam logic [PW-1:0] RST_A   = RST_V[PW-1:0];
    localparam swd_state_e    RST_ST  = (RST_A != '0) ? ST_SWALLOW : ST_MAIN;
    localparam logic [MW-1:0] M_ONE   = MW'(1);
    localparam logic [PW-1:0] A_ONE   = PW'(1);

    swd_state_e    state_q, state_d;
    logic [MW-1:0] mcnt_q, mcnt_d;
    logic [PW-1:0] acnt_q, acnt_d;
    logic          term_q, term_d;

    logic [MW-1:0] load_m;
    logic [PW-1:0] load_a;

    always_comb begin
        load_m = load_ratio[NW-1:PW];
        load_a = load_ratio[PW-1:0];
    end

    // Next-state and counter process
    always_comb begin
        state_d = state_q;
        mcnt_d  = mcnt_q;
        acnt_d  = acnt_q;
        term_d  = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_SWALLOW: begin
                    mcnt_d = mcnt_q - M_ONE;
                    acnt_d = acnt_q - A_ONE;
                    if (acnt_q == A_ONE) begin
                        state_d = ST_MAIN;          // swallow done
                    end
                end
                ST_MAIN: begin
                    if (mcnt_q == M_ONE) begin
                        term_d = 1'b1;
                        mcnt_d = load_m;
                        acnt_d = load_a;
                        state_d = (load_a != '0) ? ST_SWALLOW  // reload to swallow
                                                 : ST_MAIN;    // reload to main
                    end else begin
                        mcnt_d = mcnt_q - M_ONE;
                    end
                end
                default: state_d = ST_MAIN;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_ST;
            mcnt_q  <= RST_M;
            acnt_q  <= RST_A;
            term_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mcnt_q  <= mcnt_d;
            acnt_q  <= acnt_d;
            term_q  <= term_d;
        end
    end

    // Output process
    always_comb begin
        mod_hi     = (state_q == ST_SWALLOW);
        term_pulse = term_q;
    end
endmodule

// File: rtl/swd_mon_mux.sv
module swd_mon_mux (
    input  logic test_sel,
    input  logic div_pulse,
    input  logic port_lvl,
    output logic mon_out
);
    always_comb begin
        mon_out = test_sel ? div_pulse : port_lvl;
    end
endmodule

// File: rtl/swallow_fb_div.sv
module swallow_fb_div #(
    parameter int NW          = 15,
    parameter int PW          = 5,
    parameter int MIN_RATIO   = 1024,
    parameter int RESET_RATIO = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_tick,
    input  logic [NW-1:0] ratio_in,
    input  logic          ratio_wr,
    input  logic          test_sel,
    input  logic          port_lvl,
    output logic          mod_hi,
    output logic          div_pulse,
    output logic          mon_out
);
    logic [NW-1:0] ratio_eff;

    swd_ratio_reg #(
        .NW(NW), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)
    ) u_ratio (
        .clk(clk), .rst_n(rst_n), .ratio_in(ratio_in),
        .ratio_wr(ratio_wr), .ratio_eff(ratio_eff)
    );

    swd_count_fsm #(
        .NW(NW), .PW(PW), .RESET_RATIO(RESET_RATIO)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick),
        .load_ratio(ratio_eff), .mod_hi(mod_hi), .term_pulse(div_pulse)
    );

    swd_mon_mux u_mon (
        .test_sel(test_sel), .div_pulse(div_pulse),
        .port_lvl(port_lvl), .mon_out(mon_out)
    );
endmodule

// File: rtl/swallow_fb_div_chk.sv
module swallow_fb_div_chk (
    input logic clk,
    input logic rst_n,
    input logic pre_tick,
    input logic mod_hi,
    input logic div_pulse
);
    // R4: modulus only moves after a strobe
    assert_mod_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_tick |=> $stable(mod_hi));

    // R5: a pulse always follows a strobe
    assert_pulse_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_pulse) |-> $past(pre_tick));

    // R5: single-cycle pulse
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R3: swallow phase only begins at a period boundary
    assert_swallow_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_hi) |-> div_pulse);
endmodule

bind swallow_fb_div swallow_fb_div_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick),
    .mod_hi(mod_hi), .div_pulse(div_pulse)
);

// File: tb/swallow_fb_div_tb.sv
`timescale 1ns/1ps
module swallow_fb_div_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_tick;
    logic [14:0] ratio_in = '0;
    logic        ratio_wr = 1'b0;
    logic        test_sel = 1'b0;
    logic        port_lvl = 1'b0;
    logic        mod_hi, div_pulse, mon_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [5:0] pc = '0;
    logic       pre_en = 1'b0;

    always #4 clk = ~clk;

    swallow_fb_div u_dut (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick),
        .ratio_in(ratio_in), .ratio_wr(ratio_wr),
        .test_sel(test_sel), .port_lvl(port_lvl),
        .mod_hi(mod_hi), .div_pulse(div_pulse), .mon_out(mon_out)
    );

    // Prescaler model: /33 while mod_hi, else /32
    assign pre_tick = pre_en && (pc == (mod_hi ? 6'd32 : 6'd31));
    always @(posedge clk) begin
        if (!pre_en) pc <= '0;
        else         pc <= pre_tick ? 6'd0 : pc + 6'd1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor of R4/R5 at the ports
    logic prev_tick = 1'b0, prev_mod = 1'b0, prev_pulse = 1'b0;
    always @(negedge clk) begin
        if (rst_n && pre_en) begin
            if (mod_hi !== prev_mod)
                check(prev_tick === 1'b1, "R4 mod change w/o tick", int'(prev_tick), 1);
            if (div_pulse === 1'b1) begin
                check(prev_tick === 1'b1, "R5 pulse after tick", int'(prev_tick), 1);
                check(prev_pulse === 1'b0, "R5 pulse width", int'(prev_pulse), 0);
            end
        end
        prev_tick  = pre_tick;
        prev_mod   = mod_hi;
        prev_pulse = div_pulse;
    end

    task automatic wait_pulse();
        do @(negedge clk); while (div_pulse !== 1'b1);
    endtask

    // Called on the negedge where div_pulse is seen
    task automatic measure(output int len, output int ticks, output int sw);
        len = 0; ticks = 0; sw = 0;
        forever begin
            if (pre_tick) begin
                ticks++;
                if (mod_hi) sw++;
            end
            @(negedge clk);
            len++;
            if (div_pulse) break;
        end
    endtask

    task automatic write_ratio(input int v);
        @(negedge clk);
        ratio_in = 15'(v);
        ratio_wr = 1'b1;
        @(negedge clk);
        ratio_wr = 1'b0;
    endtask

    task automatic t_reset();
        check(div_pulse === 1'b0, "R1 div_pulse at reset", int'(div_pulse), 0);
        check(mod_hi === 1'b0, "R1 mod_hi at reset", int'(mod_hi), 0);
    endtask

    task automatic t_default_period();
        int len, ticks, sw;
        wait_pulse();
        measure(len, ticks, sw);
        check(len == 1024, "R1 R2 reset ratio period", len, 1024);
        check(sw == 0, "R3 reset swallow count", sw, 0);
    endtask

    // Write N, then verify the next full period
    task automatic t_ratio(input int wr_val, input int exp_n, input string tag);
        int len, ticks, sw;
        write_ratio(wr_val);
        wait_pulse();
        wait_pulse();
        measure(len, ticks, sw);
        check(len == exp_n, {"R2 period ", tag}, len, exp_n);
        check(ticks == exp_n / 32, {"R3 main ticks ", tag}, ticks, exp_n / 32);
        check(sw == exp_n % 32, {"R3 swallow ticks ", tag}, sw, exp_n % 32);
    endtask

    task automatic t_boundary(input int old_n, input int new_n);
        int len, ticks, sw;
        wait_pulse();
        repeat (100) @(negedge clk);
        write_ratio(new_n);
        wait_pulse();
        // interval from prior pulse covered by measuring the next one
        measure(len, ticks, sw);
        check(len == new_n, "R6 period after write", len, new_n);
        write_ratio(old_n);
        wait_pulse();
        measure(len, ticks, sw);
        check(len == old_n, "R6 period restored", len, old_n);
    endtask

    task automatic t_mid_period(input int cur_n, input int new_n);
        int len, ticks, sw, t0;
        wait_pulse();
        t0 = 0;
        // write 200 cycles into the period; that period must still be cur_n
        fork
            begin repeat (200) @(negedge clk); ratio_in = 15'(new_n); ratio_wr = 1'b1;
                  @(negedge clk); ratio_wr = 1'b0; end
            measure(len, ticks, sw);
        join
        check(len == cur_n, "R6 period in progress kept", len, cur_n);
        measure(len, ticks, sw);
        check(len == new_n, "R6 following period new", len, new_n);
        t0 = t0;
    endtask

    task automatic t_mon();
        int mism = 0, pulses = 0;
        test_sel = 1'b1;
        repeat (2200) begin
            @(negedge clk);
            if (mon_out !== div_pulse) mism++;
            if (div_pulse) pulses++;
        end
        check(mism == 0, "R8 mon follows pulse", mism, 0);
        check(pulses >= 2, "R8 pulses seen on mon", pulses, 2);
        test_sel = 1'b0;
        port_lvl = 1'b1;
        @(negedge clk);
        check(mon_out === 1'b1, "R8 mon port level 1", int'(mon_out), 1);
        port_lvl = 1'b0;
        @(negedge clk);
        check(mon_out === 1'b0, "R8 mon port level 0", int'(mon_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        pre_en = 1'b1;
        t_default_period();
        t_ratio(3232, 3232, "3232");
        t_ratio(1055, 1055, "A31");
        t_ratio(1056, 1056, "A0");
        t_mid_period(1056, 2000);
        t_boundary(2000, 1500);
        t_ratio(100, 1024, "R7 clamp 100");
        t_ratio(1023, 1024, "R7 clamp 1023");
        t_ratio(32767, 32767, "max");
        t_ratio(1024, 1024, "floor");
        t_mon();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 195000, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule